// File: doc/BRIEF.md
# Bidirectional Memory Buffer Register

This block is the one-word staging register that sits between a processor's internal buses and a shared, bidirectional memory data bus. On a store, the processor places a word on its source bus and the register captures it, then drives that word onto the memory bus. On a load, the register captures the word that memory presents and offers it to the processor's destination bus. A single active-low write-enable input picks the direction. It steers the register's input multiplexer and both output enables, so the same flip-flops serve both transfer directions.

Capture happens on the falling edge of a memory-side strobe. The block runs on the core clock. It passes the strobe through a short synchroniser and detects its falling edge, and it loads only while the active-low chip select is asserted. Tri-state drivers are modelled as a data output plus an output-enable for each bus. The memory-side enable is asserted only while the block is selected and in write direction. The destination-side enable follows a processor read-enable input, but only in read direction.

Top module: `mbr_buffer`

## Requirements
- R1: A synchronous active-high reset clears the stored word to zero. After reset, `dstBus` and `memDataOut` both read 0.
- R2: With `weN` = 0 and `csN` = 0, a falling edge of `strobe` loads `srcBus` into the register.
- R3: `memDataOe` is 1 exactly when `csN` = 0 and `weN` = 0, and 0 for the other three combinations.
- R4: With `weN` = 1 and `csN` = 0, a falling edge of `strobe` loads `memDataIn` into the register.
- R5: `dstOe` is 1 exactly when `rdEn` = 1 and `weN` = 1. It is never 1 at the same time as `memDataOe`.
- R6: The register holds its value on every cycle without a detected strobe fall, whatever `srcBus` and `memDataIn` do. A rising strobe edge also leaves it unchanged.
- R7: A strobe fall that is detected while `csN` = 1 leaves the register unchanged.
- R8: `dstBus` and `memDataOut` always carry the stored word, whatever the state of the enables.
- R9: A strobe fall that is first sampled low at a rising clock edge shows on the outputs after rising edge number SYNC_STAGES+1, counting that edge as 1. Before that edge the old value remains. With the default of 2 stages, this is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Memory-side load strobe; its falling edge loads the register |
| csN | input | 1 | Chip select, active low |
| weN | input | 1 | Direction select: 0 = write to memory, 1 = read from memory |
| rdEn | input | 1 | Processor request to drive the destination bus |
| srcBus | input | WIDTH | Processor source bus (store data) |
| memDataIn | input | WIDTH | Value seen on the memory data bus |
| memDataOut | output | WIDTH | Value the register would drive onto the memory data bus |
| memDataOe | output | 1 | Memory data bus drive enable |
| dstBus | output | WIDTH | Value the register would drive onto the processor destination bus |
| dstOe | output | 1 | Destination bus drive enable |

## Verification
The bench counts clock edges after the strobe drops. It checks that the old word survives through edge SYNC_STAGES and that the new word appears right after the next edge. A design that missed a synchroniser stage, or added one, fails there. It toggles the strobe with chip select released and with the opposite bus carrying a distinct pattern. A design that ignored the select, or muxed the wrong source, would load the wrong word. It sweeps all combinations of select, direction and read-enable. An enable decode that let both buses drive, or drove memory while deselected, would be caught there.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;  // capture the selected input this cycle
    logic selMem;  // 1: input from memory bus, 0: from source bus
    logic memOe;   // drive memory data bus
    logic dstOe;   // drive destination bus
  } mbrStrobes_t;

endpackage

// File: rtl/mbr_ctrl.sv
module mbr_ctrl
  import mbr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        strobe,
  input  logic        csN,
  input  logic        weN,
  input  logic        rdEn,
  output mbrStrobes_t strb
);

  logic syncOut;
  logic syncPrev;
  logic fallSeen;

  generate
    if (SYNC_STAGES == 0) begin : g_noSync
      assign syncOut = strobe;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          syncQ <= '0;
        end else begin
          syncQ[0] <= strobe;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            syncQ[i] <= syncQ[i-1];
          end
        end
      end
      assign syncOut = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // Cleared to 0 so a low strobe at reset release is not a fall
  always_ff @(posedge clk) begin
    if (rst) syncPrev <= 1'b0;
    else     syncPrev <= syncOut;
  end

  assign fallSeen = syncPrev & ~syncOut;

  always_comb begin
    strb.loadEn = fallSeen & ~csN;
    strb.selMem = weN;
    strb.memOe  = ~csN & ~weN;
    strb.dstOe  = rdEn & weN;
  end

  // R9: a detected fall always follows a high sample one cycle earlier
  fall_after_high_chk: assert property (@(posedge clk) disable iff (rst)
    fallSeen |-> $past(syncOut));

endmodule

// File: rtl/mbr_datapath.sv
module mbr_datapath
  import mbr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  mbrStrobes_t      strb,
  input  logic [WIDTH-1:0] srcBus,
  input  logic [WIDTH-1:0] memDataIn,
  output logic [WIDTH-1:0] memDataOut,
  output logic             memDataOe,
  output logic [WIDTH-1:0] dstBus,
  output logic             dstOe
);

  logic [WIDTH-1:0] regQ;
  logic [WIDTH-1:0] nextD;

  assign nextD = strb.selMem ? memDataIn : srcBus;

  always_ff @(posedge clk) begin
    if (rst)              regQ <= '0;
    else if (strb.loadEn) regQ <= nextD;
  end

  assign memDataOut = regQ;
  assign dstBus     = regQ;
  assign memDataOe  = strb.memOe;
  assign dstOe      = strb.dstOe;

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memDataOe, dstOe}));

  // R6
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.loadEn |=> $stable(regQ));

endmodule

// File: rtl/mbr_buffer.sv
module mbr_buffer
  import mbr_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             csN,
  input  logic             weN,
  input  logic             rdEn,
  input  logic [WIDTH-1:0] srcBus,
  input  logic [WIDTH-1:0] memDataIn,
  output logic [WIDTH-1:0] memDataOut,
  output logic             memDataOe,
  output logic [WIDTH-1:0] dstBus,
  output logic             dstOe
);

  mbrStrobes_t strb;

  mbr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rst(rst), .strobe(strobe), .csN(csN),
    .weN(weN), .rdEn(rdEn), .strb(strb)
  );

  mbr_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .srcBus(srcBus),
    .memDataIn(memDataIn), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .dstBus(dstBus), .dstOe(dstOe)
  );

  // R2
  write_load_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.loadEn && !weN) |=> (memDataOut == $past(srcBus)));

  // R4
  read_load_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.loadEn && weN) |=> (dstBus == $past(memDataIn)));

  // R7
  deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    csN |=> $stable(dstBus));

  // R8
  same_word_chk: assert property (@(posedge clk) disable iff (rst)
    dstBus == memDataOut);

endmodule

// File: tb/test_mbr_buffer.sv
module test_mbr_buffer;

  localparam int W  = 32;
  localparam int NS = 2;

  logic         clk = 1'b0;
  logic         rst, strobe, csN, weN, rdEn;
  logic [W-1:0] srcBus, memDataIn;
  logic [W-1:0] memDataOut, dstBus;
  logic         memDataOe, dstOe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mbr_buffer #(.WIDTH(W), .SYNC_STAGES(NS)) i_mbr_buffer (
    .clk(clk), .rst(rst), .strobe(strobe), .csN(csN), .weN(weN),
    .rdEn(rdEn), .srcBus(srcBus), .memDataIn(memDataIn),
    .memDataOut(memDataOut), .memDataOe(memDataOe),
    .dstBus(dstBus), .dstOe(dstOe)
  );

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Strobe high long enough to settle, then drop it; returns after drop
  task automatic dropStrobe();
    strobe = 1'b1;
    waitNeg(NS + 3);
    strobe = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1; strobe = 1'b0; csN = 1'b1; weN = 1'b1; rdEn = 1'b0;
    srcBus = '0; memDataIn = '0;
    waitNeg(3);
    rst = 1'b0;
    waitNeg(1);
    chk("R1 dstBus", dstBus, '0);
    chk("R1 memDataOut", memDataOut, '0);
  endtask

  task automatic testWrite();
    csN = 1'b0; weN = 1'b0; srcBus = 32'hA5C3_1E77; memDataIn = 32'h0BAD_F00D;
    dstropStub();
  endtask

  task automatic dstropStub();
    dropStrobe();
    waitNeg(NS);
    chk("R9 old before latency", memDataOut, '0);
    waitNeg(1);
    chk("R2 write load", memDataOut, 32'hA5C3_1E77);
    chk("R3 oe in write", {31'b0, memDataOe}, 1);
    chk("R8 dst mirrors", dstBus, 32'hA5C3_1E77);
    waitNeg(2);
  endtask

  task automatic testRead();
    csN = 1'b0; weN = 1'b1; srcBus = 32'h1111_2222; memDataIn = 32'h3C4D_5E6F;
    dropStrobe();
    waitNeg(NS);
    chk("R9 old before latency", dstBus, 32'hA5C3_1E77);
    waitNeg(1);
    chk("R4 read load", dstBus, 32'h3C4D_5E6F);
    chk("R8 mem mirrors", memDataOut, 32'h3C4D_5E6F);
    waitNeg(2);
  endtask

  task automatic testHold();
    csN = 1'b0; weN = 1'b1;
    strobe = 1'b0; waitNeg(2);
    memDataIn = 32'hFFFF_0000; srcBus = 32'h0000_FFFF;
    strobe = 1'b1;
    waitNeg(NS + 4);
    chk("R6 rise and input change", dstBus, 32'h3C4D_5E6F);
    weN = 1'b0; waitNeg(3);
    chk("R6 direction change", memDataOut, 32'h3C4D_5E6F);
  endtask

  task automatic testDeselect();
    csN = 1'b1; weN = 1'b0; srcBus = 32'hDEAD_BEEF; memDataIn = 32'hCAFE_0001;
    dropStrobe();
    waitNeg(NS + 3);
    chk("R7 write fall ignored", memDataOut, 32'h3C4D_5E6F);
    weN = 1'b1;
    dropStrobe();
    waitNeg(NS + 3);
    chk("R7 read fall ignored", dstBus, 32'h3C4D_5E6F);
  endtask

  task automatic testEnables();
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 2; w++)
        for (int r = 0; r < 2; r++) begin
          csN = c[0]; weN = w[0]; rdEn = r[0];
          #1;
          chk("R3 memDataOe", {31'b0, memDataOe}, {31'b0, (c == 0 && w == 0)});
          chk("R5 dstOe", {31'b0, dstOe}, {31'b0, (r == 1 && w == 1)});
        end
    rdEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    testReset();
    testWrite();
    testRead();
    testHold();
    testDeselect();
    testEnables();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule